// File: doc/BRIEF.md
# Fan PWM Drive and Tachometer Controller

This block drives a cooling fan and measures its speed. Software programs it through a small register bus with three registers. The configuration register holds a duty value, a polarity inversion bit, a gate enable bit, an open-collector select bit and a general status-config bit. The frequency register holds a period divisor and an 11-bit field of cycles per 10 µs. The count register returns the number of tachometer pulses seen during the last measurement window.

The PWM output is produced by two counters. A divider counts system clocks from 0 up to the divisor F. Each time the divider wraps, an N-bit phase counter advances by one. The fan is driven while the phase is below the duty value, so one PWM period lasts 2^N·(F+1) clocks. An output state machine has three states. PARKED is used while the gate is closed. DRIVE is used while the phase is below the duty. REST is used while the phase is at or above the duty. Its transitions are:
- PARKED→DRIVE and PARKED→REST when the gate opens, depending on phase against duty.
- DRIVE→REST when the phase reaches the duty.
- REST→DRIVE when the phase wraps below the duty.
- DRIVE→PARKED and REST→PARKED when the gate closes.

The drive level is then XORed with the inversion bit. In open-collector mode the data pin stays low, and the enable pin asserts only when the level is low.

The tachometer input passes through a two-flop synchroniser, and its rising edges are counted. A window sequencer has two states. RUN→CLOSE is taken on the last-but-one cycle of a window of WIN_CYCLES clocks. CLOSE→RUN is always taken after one cycle. In CLOSE the running count, including any edge seen in that cycle, is copied to the count register and the running count clears. The count saturates at all ones.

Top module: `fan_ctrl`

## Requirements
- R1: After reset all three registers read zero, pwm_o is 0 and pwm_oe is 1.
- R2: The configuration register is at byte offset 0x0. The duty sits in bits starting at 16 (DUTY_W bits wide; 23:16 by default). Bit 3 is invert, bit 2 is gate enable, bit 1 is open-collector and bit 0 is status-config. These fields read back as written, other bits read 0, and a read-modify-write of the duty leaves the other fields unchanged.
- R3: The frequency register is at offset 0x4. The divisor F is in bits 14:0 and the 10 µs cycle field is in bits 25:15. Both read back as written, and other bits read 0.
- R4: With the gate open and 0 < duty < 2^DUTY_W−1, rising edges of pwm_o are 2^DUTY_W·(F+1) clocks apart.
- R5: Over any full PWM period the output is active for duty·(F+1) clocks. With duty 0 it is never active. With maximum duty it is inactive for exactly F+1 clocks.
- R6: With invert set, the output level is the complement of the non-inverted level.
- R7: With gate enable clear, pwm_o is held at the inactive level, which equals the invert bit.
- R8: In open-collector mode pwm_o is always 0, and pwm_oe is 1 exactly when the non-open-collector level would be 0.
- R9: The count register at offset 0xC (bits CNT_W−1:0) reports the number of rising tach edges in the last complete window of WIN_CYCLES clocks. It changes only at a window close.
- R10: When more edges arrive than CNT_W bits can hold, the count holds at 2^CNT_W−1 and does not wrap.
- R11: Writes to offsets 0x8 and 0xC change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tach_i | input | 1 | Asynchronous tachometer pulse input |
| pwm_o | output | 1 | PWM data output |
| pwm_oe | output | 1 | PWM output drive enable (open-collector release when 0) |

## Verification
The bench builds the block with DUTY_W=4, CNT_W=6 and WIN_CYCLES=400. This makes a PWM period only 16·(F+1) clocks long, so every duty value can be swept for several divisors, and the active time of each period can be compared with duty·(F+1). The short window and narrow counter let the bench drive periodic tach pulses whose period divides the window. Each window therefore holds an exact, known edge count, and saturation at 63 is reached within a few hundred cycles.

// File: rtl/fan_ctrl_pkg.sv
package fan_ctrl_pkg;
    localparam int BUS_AW = 4;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] ADDR_CFG   = 4'h0;
    localparam logic [BUS_AW-1:0] ADDR_FREQ  = 4'h4;
    localparam logic [BUS_AW-1:0] ADDR_COUNT = 4'hC;

    localparam int CFG_STAT_POS = 0;
    localparam int CFG_OC_POS   = 1;
    localparam int CFG_GATE_POS = 2;
    localparam int CFG_INV_POS  = 3;
    localparam int CFG_DUTY_POS = 16;

    localparam int FREQ_TICK_POS = 15;
    localparam int TICK_W        = 11;

    typedef enum logic [1:0] {
        PWM_PARKED = 2'd0,
        PWM_DRIVE  = 2'd1,
        PWM_REST   = 2'd2
    } pwm_state_t;

    typedef enum logic {
        WIN_RUN   = 1'b0,
        WIN_CLOSE = 1'b1
    } win_state_t;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
    import fan_ctrl_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int DIV_W  = 15,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic              we,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DUTY_W-1:0] duty_o,
    output logic              inv_o,
    output logic              gate_o,
    output logic              oc_o,
    output logic [DIV_W-1:0]  div_o
);
    logic [DUTY_W-1:0] duty_q;
    logic              inv_q, gate_q, oc_q, stat_q;
    logic [DIV_W-1:0]  div_q;
    logic [TICK_W-1:0] tick_q;
    logic              unused_wbits;

    assign unused_wbits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            inv_q  <= 1'b0;
            gate_q <= 1'b0;
            oc_q   <= 1'b0;
            stat_q <= 1'b0;
            div_q  <= '0;
            tick_q <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CFG: begin
                    duty_q <= wdata[CFG_DUTY_POS +: DUTY_W];
                    inv_q  <= wdata[CFG_INV_POS];
                    gate_q <= wdata[CFG_GATE_POS];
                    oc_q   <= wdata[CFG_OC_POS];
                    stat_q <= wdata[CFG_STAT_POS];
                end
                ADDR_FREQ: begin
                    div_q  <= wdata[DIV_W-1:0];
                    tick_q <= wdata[FREQ_TICK_POS +: TICK_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CFG: begin
                rdata[CFG_DUTY_POS +: DUTY_W] = duty_q;
                rdata[CFG_INV_POS]            = inv_q;
                rdata[CFG_GATE_POS]           = gate_q;
                rdata[CFG_OC_POS]             = oc_q;
                rdata[CFG_STAT_POS]           = stat_q;
            end
            ADDR_FREQ: begin
                rdata[DIV_W-1:0]                = div_q;
                rdata[FREQ_TICK_POS +: TICK_W]  = tick_q;
            end
            ADDR_COUNT: rdata[CNT_W-1:0] = count;
            default: rdata = '0;
        endcase
    end

    assign duty_o = duty_q;
    assign inv_o  = inv_q;
    assign gate_o = gate_q;
    assign oc_o   = oc_q;
    assign div_o  = div_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
    import fan_ctrl_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int DIV_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate,
    input  logic              inv,
    input  logic              oc,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DIV_W-1:0]  div_val,
    output logic              pwm_o,
    output logic              pwm_oe,
    output pwm_state_t        state_o,
    output logic [DUTY_W-1:0] phase_o,
    output logic [DIV_W-1:0]  div_cnt_o
);
    localparam logic [DIV_W-1:0]  DIV_STEP = DIV_W'(1);
    localparam logic [DUTY_W-1:0] PH_STEP  = DUTY_W'(1);

    logic [DIV_W-1:0]  div_q;
    logic [DUTY_W-1:0] phase_q;
    pwm_state_t        state_q, state_d;
    logic              drive_lvl, line_lvl;

    // divider and phase counters: phase advances once per (F+1) clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= '0;
        end else if (div_q >= div_val) begin
            div_q   <= '0;
            phase_q <= phase_q + PH_STEP;
        end else begin
            div_q   <= div_q + DIV_STEP;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWM_PARKED: begin
                if (gate) state_d = (phase_q < duty) ? PWM_DRIVE : PWM_REST;
            end
            PWM_DRIVE: begin
                if (!gate)               state_d = PWM_PARKED;
                else if (phase_q >= duty) state_d = PWM_REST;
            end
            PWM_REST: begin
                if (!gate)               state_d = PWM_PARKED;
                else if (phase_q < duty) state_d = PWM_DRIVE;
            end
            default: state_d = PWM_PARKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWM_PARKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PWM_DRIVE: drive_lvl = 1'b1;
            default:   drive_lvl = 1'b0;
        endcase
        line_lvl = drive_lvl ^ inv;
        if (oc) begin
            pwm_o  = 1'b0;
            pwm_oe = ~line_lvl;
        end else begin
            pwm_o  = line_lvl;
            pwm_oe = 1'b1;
        end
    end

    assign state_o   = state_q;
    assign phase_o   = phase_q;
    assign div_cnt_o = div_q;
endmodule

// File: rtl/fan_tach_win.sv
module fan_tach_win
    import fan_ctrl_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int WIN_CYCLES = 250_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] run_cnt_o,
    output win_state_t       state_o
);
    localparam int               TMR_W    = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_CYCLES - 2);
    localparam logic [TMR_W-1:0] TMR_STEP = TMR_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    logic [2:0]       sync_q;
    logic             edge_seen;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] run_q, latch_q, bumped;
    win_state_t       state_q, state_d;

    // two synchroniser flops plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tach_i};
    end

    assign edge_seen = sync_q[1] & ~sync_q[2];
    assign bumped    = (run_q == CNT_MAX) ? CNT_MAX : run_q + CNT_W'(edge_seen);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_RUN:   if (tmr_q == TMR_LAST) state_d = WIN_CLOSE;
            WIN_CLOSE: state_d = WIN_RUN;
            default:   state_d = WIN_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_RUN;
        else        state_q <= state_d;
    end

    // datapath controlled by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            run_q   <= '0;
            latch_q <= '0;
        end else begin
            unique case (state_q)
                WIN_CLOSE: begin
                    latch_q <= bumped;
                    run_q   <= '0;
                    tmr_q   <= '0;
                end
                default: begin
                    run_q   <= bumped;
                    tmr_q   <= tmr_q + TMR_STEP;
                end
            endcase
        end
    end

    assign count_o   = latch_q;
    assign run_cnt_o = run_q;
    assign state_o   = state_q;
endmodule

// File: rtl/fan_ctrl.sv
module fan_ctrl
    import fan_ctrl_pkg::*;
#(
    parameter int DUTY_W     = 8,
    parameter int DIV_W      = 15,
    parameter int CNT_W      = 16,
    parameter int WIN_CYCLES = 250_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tach_i,
    output logic        pwm_o,
    output logic        pwm_oe
);
    logic [DUTY_W-1:0] cfg_duty;
    logic              cfg_inv, cfg_gate, cfg_oc;
    logic [DIV_W-1:0]  cfg_div;
    logic [CNT_W-1:0]  tach_latched, tach_run_cnt;
    pwm_state_t        pwm_state;
    logic [DUTY_W-1:0] pwm_phase;
    logic [DIV_W-1:0]  pwm_div_cnt;
    win_state_t        win_state;

    fan_regs #(.DUTY_W(DUTY_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .count  (tach_latched),
        .duty_o (cfg_duty),
        .inv_o  (cfg_inv),
        .gate_o (cfg_gate),
        .oc_o   (cfg_oc),
        .div_o  (cfg_div)
    );

    fan_pwm_gen #(.DUTY_W(DUTY_W), .DIV_W(DIV_W)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (cfg_gate),
        .inv       (cfg_inv),
        .oc        (cfg_oc),
        .duty      (cfg_duty),
        .div_val   (cfg_div),
        .pwm_o     (pwm_o),
        .pwm_oe    (pwm_oe),
        .state_o   (pwm_state),
        .phase_o   (pwm_phase),
        .div_cnt_o (pwm_div_cnt)
    );

    fan_tach_win #(.CNT_W(CNT_W), .WIN_CYCLES(WIN_CYCLES)) u_tach (
        .clk       (clk),
        .rst_n     (rst_n),
        .tach_i    (tach_i),
        .count_o   (tach_latched),
        .run_cnt_o (tach_run_cnt),
        .state_o   (win_state)
    );
endmodule

// File: rtl/fan_ctrl_chk.sv
module fan_ctrl_chk
    import fan_ctrl_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int DIV_W  = 15,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_o,
    input logic              pwm_oe,
    input logic              cfg_gate,
    input logic              cfg_inv,
    input logic              cfg_oc,
    input logic [DUTY_W-1:0] cfg_duty,
    input logic [DIV_W-1:0]  cfg_div,
    input pwm_state_t        pwm_state,
    input logic [DUTY_W-1:0] pwm_phase,
    input logic [DIV_W-1:0]  pwm_div_cnt,
    input logic [CNT_W-1:0]  tach_run_cnt,
    input logic [CNT_W-1:0]  tach_latched,
    input win_state_t        win_state
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_div_cnt < cfg_div) |=> $stable(pwm_phase));

    // R5
    zero_duty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_duty == '0) |=> (pwm_state != PWM_DRIVE));

    // R7
    gate_closed_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_gate) |=> (cfg_oc || (pwm_o == cfg_inv)));

    // R8
    open_collector_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_oc |-> !(pwm_o && pwm_oe));

    // R9
    latch_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_state == WIN_RUN) |=> $stable(tach_latched));

    // R10
    count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tach_run_cnt == CNT_MAX && win_state == WIN_RUN) |=> (tach_run_cnt == CNT_MAX));
endmodule

bind fan_ctrl fan_ctrl_chk #(.DUTY_W(DUTY_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_o        (pwm_o),
    .pwm_oe       (pwm_oe),
    .cfg_gate     (cfg_gate),
    .cfg_inv      (cfg_inv),
    .cfg_oc       (cfg_oc),
    .cfg_duty     (cfg_duty),
    .cfg_div      (cfg_div),
    .pwm_state    (pwm_state),
    .pwm_phase    (pwm_phase),
    .pwm_div_cnt  (pwm_div_cnt),
    .tach_run_cnt (tach_run_cnt),
    .tach_latched (tach_latched),
    .win_state    (win_state)
);

// File: tb/tb_fan_ctrl.sv
`timescale 1ns/1ps
module tb_fan_ctrl;
    localparam int DW  = 4;
    localparam int CW  = 6;
    localparam int WIN = 400;
    localparam int PH  = 1 << DW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        tach_i = 1'b0;
    logic        pwm_o, pwm_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int tach_per = 0;
    int tach_tc  = 0;
    bit done   = 1'b0;

    fan_ctrl #(.DUTY_W(DW), .DIV_W(15), .CNT_W(CW), .WIN_CYCLES(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tach_i(tach_i),
        .pwm_o(pwm_o), .pwm_oe(pwm_oe)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // periodic tach source, half-high for tach_per cycles
    always @(negedge clk) begin
        tach_tc = tach_tc + 1;
        tach_i  = (tach_per > 0) && ((tach_tc % tach_per) < (tach_per / 2));
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] cfg_word(int duty, bit inv, bit gate, bit oc, bit stat);
        return (32'(duty) << 16) | (32'(inv) << 3) | (32'(gate) << 2) | (32'(oc) << 1) | 32'(stat);
    endfunction

    // counts cycles with pwm_o high, pwm_oe high, and pwm_o high in open-collector use
    task automatic measure(input int len, output int hi, output int oe_hi);
        hi = 0; oe_hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            #1;
            if (pwm_o)  hi++;
            if (pwm_oe) oe_hi++;
        end
    endtask

    task automatic rise_gap(output int gap);
        int t1;
        logic prev;
        @(negedge clk); #1 prev = pwm_o;
        forever begin
            @(negedge clk); #1;
            if (pwm_o && !prev) break;
            prev = pwm_o;
        end
        t1 = cyc;
        prev = pwm_o;
        forever begin
            @(negedge clk); #1;
            if (pwm_o && !prev) break;
            prev = pwm_o;
        end
        gap = cyc - t1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, rd2;
        int hi, oeh, gap, period;
        int f_list[4] = '{0, 1, 2, 5};

        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h0, rd); check("R1", "cfg reset", rd, 0);
        bus_read(4'h4, rd); check("R1", "freq reset", rd, 0);
        bus_read(4'hC, rd); check("R1", "count reset", rd, 0);
        check("R1", "pwm_o reset", pwm_o, 0);
        check("R1", "pwm_oe reset", pwm_oe, 1);

        // R2 readback, unused bits zero, read-modify-write
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, rd); check("R2", "cfg all ones", rd, 32'h000F_000F);
        bus_write(4'h0, cfg_word(9, 1, 0, 0, 1));
        bus_read(4'h0, rd); check("R2", "cfg fields", rd, cfg_word(9, 1, 0, 0, 1));
        rd = (rd & ~32'h00FF_0000) | (32'd3 << 16);
        bus_write(4'h0, rd);
        bus_read(4'h0, rd2); check("R2", "cfg rmw duty", rd2, cfg_word(3, 1, 0, 0, 1));

        // R3 frequency register fields
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, rd); check("R3", "freq all ones", rd, 32'h03FF_FFFF);
        bus_write(4'h4, (32'd1234 << 15) | 32'd7);
        bus_read(4'h4, rd); check("R3", "freq fields", rd, (32'd1234 << 15) | 32'd7);

        // R11 writes to 0x8 and 0xC are ignored
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'h0, rd); check("R11", "cfg after stray write", rd, cfg_word(3, 1, 0, 0, 1));
        bus_read(4'h4, rd); check("R11", "freq after stray write", rd, (32'd1234 << 15) | 32'd7);
        bus_read(4'hC, rd); check("R11", "count after stray write", rd, 0);

        // R5 duty sweep for several divisors; R4 period per divisor
        foreach (f_list[k]) begin
            period = PH * (f_list[k] + 1);
            bus_write(4'h4, 32'(f_list[k]));
            for (int d = 0; d < PH; d++) begin
                bus_write(4'h0, cfg_word(d, 0, 1, 0, 0));
                repeat (2 * period) @(negedge clk);
                measure(period, hi, oeh);
                check("R5", $sformatf("active cycles F=%0d duty=%0d", f_list[k], d), hi, d * (f_list[k] + 1));
            end
            bus_write(4'h0, cfg_word(5, 0, 1, 0, 0));
            repeat (2 * period) @(negedge clk);
            rise_gap(gap);
            check("R4", $sformatf("period F=%0d", f_list[k]), gap, period);
        end

        // R6 inversion
        bus_write(4'h4, 32'd1);
        period = PH * 2;
        bus_write(4'h0, cfg_word(5, 1, 1, 0, 0));
        repeat (2 * period) @(negedge clk);
        measure(period, hi, oeh);
        check("R6", "inverted high cycles", hi, period - 10);

        // R7 gate closed forces inactive level
        bus_write(4'h0, cfg_word(5, 1, 0, 0, 0));
        repeat (4) @(negedge clk);
        measure(period, hi, oeh);
        check("R7", "gate off inverted", hi, period);
        bus_write(4'h0, cfg_word(15, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        measure(period, hi, oeh);
        check("R7", "gate off plain", hi, 0);

        // R8 open-collector drive
        bus_write(4'h0, cfg_word(5, 0, 1, 1, 0));
        repeat (2 * period) @(negedge clk);
        measure(period, hi, oeh);
        check("R8", "oc data high cycles", hi, 0);
        check("R8", "oc enable cycles", oeh, period - 10);

        // R9 tach counting, R10 saturation
        tach_per = 8;
        repeat (2 * WIN + 20) @(negedge clk);
        bus_read(4'hC, rd); check("R9", "count period 8", rd, WIN / 8);
        tach_per = 10;
        repeat (2 * WIN + 20) @(negedge clk);
        bus_read(4'hC, rd); check("R9", "count period 10", rd, WIN / 10);
        tach_per = 4;
        repeat (2 * WIN + 20) @(negedge clk);
        bus_read(4'hC, rd); check("R10", "count saturated", rd, (1 << CW) - 1);
        tach_per = 0;
        repeat (2 * WIN + 20) @(negedge clk);
        bus_read(4'hC, rd); check("R9", "count idle", rd, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule